// File: doc/BRIEF.md
# Two-Level Masked Interrupt Arbiter

The arbiter sits beside a CPU core. It gathers a parameterised set of maskable interrupt lines and one non-maskable line, and it chooses at most one of them at each instruction boundary. Each maskable source has an enable bit and a one-bit priority level. Two mask bits from the core's condition register decide which levels may be taken. The arbiter also applies a fixed tie-break between sources that have the same level.

When a request is taken, the block raises a one-cycle accept pulse together with the vector number of the winner. In the same cycle it tells the core to set both mask bits. Saving the program counter and condition register, and fetching through the vector, remain the core's job. Maskable requests are level-held by their sources, so a request that loses stays pending until it wins.

Top module: `irq_arbiter`

## Requirements
- R1: A maskable source takes part in arbitration only while both its request line and its enable bit are 1.
- R2: Among eligible maskable requests, any source whose level bit is 1 wins over every source whose level bit is 0.
- R3: Among eligible requests of the same level, the lowest source index wins.
- R4: With maskI = 0, the selected request is accepted at either level, whatever maskUi is.
- R5: With maskI = 1 and maskUi = 0, only level-1 requests are accepted; level-0 requests produce no acceptance.
- R6: With maskI = 1 and maskUi = 1, no maskable request is accepted; only the non-maskable input can be.
- R7: Acceptance happens only on a clock edge where instrEnd is 1. acceptPulse is then high for exactly the following cycle, and it is never high otherwise.
- R8: newMaskI and newMaskUi are both 1 in the cycle in which acceptPulse is 1, and both 0 in every other cycle.
- R9: acceptVec equals NMI_VEC (default 7) for the non-maskable source and NMI_VEC+1+i (default 8+i) for maskable source i. It is valid while acceptPulse is 1.
- R10: A rising edge on nmiIn creates one pending non-maskable event. That event outranks every maskable request, ignores the mask bits, and is accepted exactly once, even if nmiIn stays high.
- R11: A request that loses arbitration is not dropped: once the winner withdraws, the next boundary accepts the former loser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcReq | input | NUM_SRC | Raw request lines of the maskable sources |
| srcEn | input | NUM_SRC | Per-source enable bits |
| srcLevel | input | NUM_SRC | Per-source priority level (1 = high) |
| nmiIn | input | 1 | Non-maskable request, edge detected |
| maskI | input | 1 | Primary mask bit from the condition register |
| maskUi | input | 1 | Secondary mask bit from the condition register |
| instrEnd | input | 1 | Instruction-boundary strobe |
| acceptPulse | output | 1 | One-cycle acceptance pulse |
| acceptVec | output | VEC_W | Vector number of the accepted source |
| newMaskI | output | 1 | Value the core loads into maskI on acceptance |
| newMaskUi | output | 1 | Value the core loads into maskUi on acceptance |

## Verification
The assertions assume that the core keeps the request, enable, level and mask inputs as valid binary values on every edge. They also assume that a source withdraws its request only by deasserting its line. The checker records those inputs at each edge and compares every accept pulse against them. For this reason the bench changes inputs only on falling edges and holds them across the boundary edge it tests. The non-maskable line is raised at least one edge before the boundary at which the bench expects it to be taken.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // Strobes from control to datapath for one arbitration edge
  typedef struct packed {
    logic take;     // an acceptance happens on this edge
    logic takeNmi;  // the accepted source is the non-maskable one
  } arbStrobe_t;
endpackage

// File: rtl/irq_arb_control.sv
module irq_arb_control
  import irq_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       nmiIn,
  input  logic       instrEnd,
  input  logic       candValid,
  output arbStrobe_t strobe
);
  logic nmiPrev;
  logic nmiPend;
  logic nmiEdge;

  assign nmiEdge = nmiIn & ~nmiPrev;

  always_comb begin
    strobe = '0;
    if (instrEnd) begin
      if (nmiPend) begin
        strobe.take    = 1'b1;
        strobe.takeNmi = 1'b1;
      end else if (candValid) begin
        strobe.take = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPrev <= 1'b0;
      nmiPend <= 1'b0;
    end else begin
      nmiPrev <= nmiIn;
      nmiPend <= (nmiPend & ~strobe.takeNmi) | nmiEdge;
    end
  end
endmodule

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 6,
  parameter int NMI_VEC = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic               maskI,
  input  logic               maskUi,
  input  arbStrobe_t         strobe,
  output logic               candValid,
  output logic               acceptPulse,
  output logic [VEC_W-1:0]   acceptVec,
  output logic               newMaskI,
  output logic               newMaskUi
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [VEC_W-1:0] NMI_V  = VEC_W'(NMI_VEC);
  localparam logic [VEC_W-1:0] BASE_V = VEC_W'(NMI_VEC + 1);

  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] hiReq;
  logic [NUM_SRC-1:0] loReq;
  logic [NUM_SRC-1:0] hiElig;
  logic [NUM_SRC-1:0] loElig;
  logic [NUM_SRC-1:0] chosenSet;
  logic [IDX_W-1:0]   candIdx;
  logic               allowHi;
  logic               allowLo;

  // Per-source gating, one slice per source
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    assign pending[g] = srcReq[g] & srcEn[g];
    assign hiReq[g]   = pending[g] & srcLevel[g];
    assign loReq[g]   = pending[g] & ~srcLevel[g];
  end

  assign allowHi = ~maskI | ~maskUi;
  assign allowLo = ~maskI;
  assign hiElig  = allowHi ? hiReq : '0;
  assign loElig  = allowLo ? loReq : '0;
  assign chosenSet = (|hiElig) ? hiElig : loElig;
  assign candValid = |chosenSet;

  // Lowest index of the chosen set wins
  always_comb begin
    candIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (chosenSet[i]) candIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acceptPulse <= 1'b0;
      acceptVec   <= '0;
      newMaskI    <= 1'b0;
      newMaskUi   <= 1'b0;
    end else begin
      acceptPulse <= strobe.take;
      newMaskI    <= strobe.take;
      newMaskUi   <= strobe.take;
      if (strobe.take) begin
        acceptVec <= strobe.takeNmi ? NMI_V : BASE_V + VEC_W'(candIdx);
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 6,
  parameter int NMI_VEC = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic               nmiIn,
  input  logic               maskI,
  input  logic               maskUi,
  input  logic               instrEnd,
  output logic               acceptPulse,
  output logic [VEC_W-1:0]   acceptVec,
  output logic               newMaskI,
  output logic               newMaskUi
);
  irq_arb_pkg::arbStrobe_t strobe;
  logic candValid;

  irq_arb_control uCtl (
    .clk(clk), .rstN(rstN), .nmiIn(nmiIn), .instrEnd(instrEnd),
    .candValid(candValid), .strobe(strobe)
  );

  irq_arb_datapath #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) uDp (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcEn(srcEn), .srcLevel(srcLevel),
    .maskI(maskI), .maskUi(maskUi), .strobe(strobe), .candValid(candValid),
    .acceptPulse(acceptPulse), .acceptVec(acceptVec),
    .newMaskI(newMaskI), .newMaskUi(newMaskUi)
  );
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 6,
  parameter int NMI_VEC = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcReq,
  input logic [NUM_SRC-1:0] srcEn,
  input logic [NUM_SRC-1:0] srcLevel,
  input logic               maskI,
  input logic               maskUi,
  input logic               instrEnd,
  input logic               acceptPulse,
  input logic [VEC_W-1:0]   acceptVec,
  input logic               newMaskI,
  input logic               newMaskUi
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [VEC_W-1:0] NMI_V  = VEC_W'(NMI_VEC);
  localparam logic [VEC_W-1:0] BASE_V = VEC_W'(NMI_VEC + 1);

  logic [NUM_SRC-1:0] qReq, qEn, qLevel;
  logic qMaskI, qMaskUi, qInstr;
  logic [VEC_W-1:0] offs;
  logic [IDX_W-1:0] idx;
  logic isNmi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qReq <= '0; qEn <= '0; qLevel <= '0;
      qMaskI <= 1'b0; qMaskUi <= 1'b0; qInstr <= 1'b0;
    end else begin
      qReq <= srcReq; qEn <= srcEn; qLevel <= srcLevel;
      qMaskI <= maskI; qMaskUi <= maskUi; qInstr <= instrEnd;
    end
  end

  assign isNmi = (acceptVec == NMI_V);
  assign offs  = acceptVec - BASE_V;
  assign idx   = offs[IDX_W-1:0];

  AST_PULSE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    acceptPulse |-> qInstr);  // R7
  AST_MASK_SET_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    acceptPulse |-> (newMaskI && newMaskUi));  // R8
  AST_MASK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !acceptPulse |-> (!newMaskI && !newMaskUi));  // R8
  AST_FULL_MASK_NMI_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (acceptPulse && qMaskI && qMaskUi) |-> isNmi);  // R6
  AST_HALF_MASK_LEVEL1: assert property (@(posedge clk) disable iff (!rstN)
    (acceptPulse && qMaskI && !qMaskUi && !isNmi) |-> qLevel[idx]);  // R5
  AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (acceptPulse && !isNmi) |-> (qReq[idx] && qEn[idx]));  // R1
endmodule

bind irq_arbiter irq_arb_checker #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) uChk (
  .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcEn(srcEn), .srcLevel(srcLevel),
  .maskI(maskI), .maskUi(maskUi), .instrEnd(instrEnd), .acceptPulse(acceptPulse),
  .acceptVec(acceptVec), .newMaskI(newMaskI), .newMaskUi(newMaskUi)
);

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
  localparam int N = 8;
  localparam int VW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] srcReq = '0, srcEn = '0, srcLevel = '0;
  logic nmiIn = 1'b0, maskI = 1'b0, maskUi = 1'b0, instrEnd = 1'b0;
  logic acceptPulse, newMaskI, newMaskUi;
  logic [VW-1:0] acceptVec;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  irq_arbiter dut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcEn(srcEn), .srcLevel(srcLevel),
    .nmiIn(nmiIn), .maskI(maskI), .maskUi(maskUi), .instrEnd(instrEnd),
    .acceptPulse(acceptPulse), .acceptVec(acceptVec),
    .newMaskI(newMaskI), .newMaskUi(newMaskUi)
  );

  typedef struct packed {
    logic [N-1:0] req;
    logic [N-1:0] en;
    logic [N-1:0] lvl;
    logic mi;
    logic mui;
    logic acc;
    logic [VW-1:0] vec;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{8'h01, 8'h01, 8'h00, 1'b0, 1'b0, 1'b1, 6'd8},   // R4 level 0 taken
    '{8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 6'd0},   // R1 disabled
    '{8'h0C, 8'hFF, 8'h08, 1'b0, 1'b0, 1'b1, 6'd11},  // R2 level 1 beats
    '{8'h0C, 8'hFF, 8'h0C, 1'b0, 1'b0, 1'b1, 6'd10},  // R3 tie
    '{8'h0C, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, 6'd0},   // R5 level 0 held
    '{8'h0C, 8'hFF, 8'h08, 1'b1, 1'b0, 1'b1, 6'd11},  // R5 level 1 taken
    '{8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 6'd0},   // R6 all held
    '{8'h80, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b1, 6'd15},  // R4 UI ignored
    '{8'hA0, 8'h20, 8'h80, 1'b0, 1'b0, 1'b1, 6'd13},  // R1 enable filter
    '{8'h30, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 6'd12}   // R3 tie level 0
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulse instrEnd for one edge, check outputs in the following cycle
  task automatic boundary(input bit expAcc, input int expVec, input string req);
    instrEnd = 1'b1;
    @(posedge clk); @(negedge clk);
    instrEnd = 1'b0;
    check(acceptPulse == expAcc, {req, " pulse"}, acceptPulse, expAcc);
    check(newMaskI == expAcc && newMaskUi == expAcc, "R8 newMask",
          {newMaskI, newMaskUi}, expAcc ? 3 : 0);
    if (expAcc) check(acceptVec == VW'(expVec), {req, " vec R9"}, acceptVec, expVec);
    @(posedge clk); @(negedge clk);
    check(acceptPulse == 1'b0, "R7 single cycle", acceptPulse, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(acceptPulse == 0 && newMaskI == 0 && newMaskUi == 0, "R7 reset", acceptPulse, 0);
    rstN = 1'b1;
    @(negedge clk);

    foreach (TBL[k]) begin
      srcReq = TBL[k].req; srcEn = TBL[k].en; srcLevel = TBL[k].lvl;
      maskI = TBL[k].mi; maskUi = TBL[k].mui;
      boundary(TBL[k].acc, int'(TBL[k].vec), $sformatf("table %0d", k));
      srcReq = '0;
    end

    // R7: no acceptance without the boundary strobe
    srcReq = 8'h01; srcEn = 8'hFF; srcLevel = '0; maskI = 0; maskUi = 0;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); @(negedge clk);
      check(acceptPulse == 0, "R7 no strobe", acceptPulse, 0);
    end

    // R10 + R6: NMI taken under full mask, ahead of pending maskables
    srcReq = 8'hFF; srcLevel = 8'hFF; maskI = 1; maskUi = 1;
    nmiIn = 1'b1;
    @(posedge clk); @(negedge clk);
    boundary(1'b1, 7, "R10 nmi full mask");
    boundary(1'b0, 0, "R10 nmi once");
    nmiIn = 1'b0;
    @(posedge clk); @(negedge clk);

    // R10: NMI beats level 1 with mask open
    maskI = 0; maskUi = 0; srcReq = 8'h02; srcLevel = 8'h02;
    nmiIn = 1'b1;
    @(posedge clk); @(negedge clk);
    nmiIn = 1'b0;
    boundary(1'b1, 7, "R10 nmi over level1");

    // R11: loser stays pending
    srcReq = 8'h06; srcLevel = 8'h04;
    boundary(1'b1, 10, "R11 first winner");
    srcReq = 8'h02;
    boundary(1'b1, 9, "R11 loser later");

    // R5: held level-0 request taken once mask opens
    srcReq = 8'h08; srcLevel = 8'h00; maskI = 1; maskUi = 0;
    boundary(1'b0, 0, "R5 held");
    maskI = 0;
    boundary(1'b1, 11, "R5 released");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule